// File: doc/BRIEF.md
# Floating-point register stack controller

This block owns an eight-slot register stack for a floating-point unit. Instructions name their operands relative to a rotating top pointer. The block takes one two-byte register-form instruction per cycle through a valid/ready handshake and decodes it. It turns each relative index into a physical slot. It then carries out the stack side of the instruction: pushes, pops, exchanges, frees, pointer steps, and the write-back of an arithmetic result into the chosen destination.

The arithmetic itself is done outside. In the cycle an arithmetic instruction is accepted, the block presents the destination and source operand values, the function field and the operand-order flag. The external unit returns its result on `res_data` in that same cycle. The result write and any pops finish at the accepting clock edge, so the next instruction sees the updated stack.

Each slot has an empty tag. A read of an empty operand raises a sticky underflow flag. A push into a slot that still holds data raises a sticky overflow flag. In both cases the instruction leaves the stack unchanged. A read port lets any relative entry be observed.

Top module: `fpstk_ctrl`

## Requirements
- R1: An instruction whose first byte does not start with bits 11011, or whose two bytes match none of the encodings in R3 to R11, is still accepted. It changes no value, tag, pointer or flag, and `bad_op` is high for exactly the cycle after it was accepted.
- R2: `rd_data` and `rd_empty` show the slot at physical index (`top_ptr` + `rd_rel`) mod 8, where relative index 0 is the stack top and 7 is the eighth element.
- R3: First byte 0xD9 with second byte 11101kkk (kkk not 111) is a push of the result. It moves the top one slot down, writes `res_data` there and tags that slot valid.
- R4: First byte 0xD9 with second byte 11000iii pushes a copy of ST(i). ST(i) is resolved against the top as it was before the push moves it.
- R5: First byte 11011dP0 (dP not 01) with second byte 11ffRiii is the arithmetic form. In its accept cycle, with both operands valid, `op_fire` is high and `op_func` equals ff. `op_dst_data` is ST(0) when d=0 and ST(i) when d=1, and `op_src_data` is the other operand. `res_data` is written into the destination at that edge.
- R6: In the arithmetic form, `op_reverse` equals R xor d. A value of 1 means source OP destination.
- R7: In the arithmetic form with P=1, the result is written, then the old top is tagged empty and the top moves up by one, all at the same edge.
- R8: First byte 0xDE with second byte 0xD9 pops twice. It tags ST(0) and ST(1) empty and moves the top up by two. This encoding is not treated as an arithmetic form.
- R9: First byte 0xD9 with second byte 0xF7 moves the top up by one, and with 0xF6 moves it down by one. No slot value or tag changes.
- R10: First byte 0xD9 with second byte 11001iii swaps the values of ST(0) and ST(i).
- R11: First byte 0xDD with second byte 11000iii tags ST(i) empty and leaves the top pointer where it is.
- R12: An empty operand sets the sticky `underflow` flag and the instruction has no other effect. The operands checked are ST(0) and ST(i) for swap and arithmetic, ST(i) for copy, and ST(0) and ST(1) for pop-twice.
- R13: A push or copy whose target slot (one below the top) is still valid sets the sticky `overflow` flag and has no other effect.
- R14: After reset `top_ptr` is 0, every slot is empty and both flags are clear. `in_ready` is high from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present on the byte inputs |
| in_ready | output | 1 | Block can accept an instruction this cycle |
| in_byte0 | input | 8 | First instruction byte |
| in_byte1 | input | 8 | Second instruction byte |
| res_data | input | DATA_W | Result from the external unit, also the value for result pushes |
| op_fire | output | 1 | An arithmetic instruction is being executed this cycle |
| op_func | output | 2 | Arithmetic function field |
| op_reverse | output | 1 | Operand order: 1 means source OP destination |
| op_dst_data | output | DATA_W | Destination operand value |
| op_src_data | output | DATA_W | Source operand value |
| rd_rel | input | 3 | Relative index for the observation port |
| rd_data | output | DATA_W | Value of the observed entry |
| rd_empty | output | 1 | Empty tag of the observed entry |
| top_ptr | output | 3 | Current physical top index |
| bad_op | output | 1 | Pulse: previous accepted instruction was not recognised |
| overflow | output | 1 | Sticky stack overflow |
| underflow | output | 1 | Sticky stack underflow |

## Verification
Some properties are checked on every cycle. Both fault flags must stay set once raised. A rejected instruction must leave the top pointer unmoved. The pointer-increment and pop-twice encodings must move the top by one and two. `op_fire` may only appear on an accepted handshake, with an operand-order flag that matches the opcode bits. The rest depends on the stack contents, and only the bench's scenarios can show it: whether the result lands in the right physical slot, a copy reading its source before the top moves, swaps across every index, frees, and the suppression of an instruction on overflow or underflow. For these the bench keeps its own model of slots, tags and pointer and compares every relative entry after each instruction.

// File: rtl/fpstk_pkg.sv
`timescale 1ns/100ps
// Shared constants and types for the register stack controller.
// Assumes the relative index field of the opcode is three bits wide,
// which fixes the stack depth at eight.
package fpstk_pkg;
    localparam int IDX_W       = 3;
    localparam int STACK_DEPTH = 1 << IDX_W;
    localparam logic [4:0] FAMILY_TAG = 5'b11011;

    typedef enum logic [3:0] {
        OPK_ILLEGAL,
        OPK_TOP_INC,
        OPK_TOP_DEC,
        OPK_EXCH,
        OPK_COPY,
        OPK_PUSH_RES,
        OPK_FREE,
        OPK_POP_TWICE,
        OPK_ARITH
    } opk_e;

    typedef struct packed {
        opk_e             kind;
        logic [IDX_W-1:0] idx;
        logic             dst_sel;
        logic             pop;
        logic             rev;
        logic [1:0]       func;
    } dec_t;
endpackage

// File: rtl/fpstk_decode.sv
`timescale 1ns/100ps
// Opcode decoder: classifies a two-byte register-form instruction and
// extracts its index, destination, pop, order and function fields.
// Purely combinational; assumes both bytes are stable while valid.
module fpstk_decode
    import fpstk_pkg::*;
(
    input  logic [7:0] byte0,
    input  logic [7:0] byte1,
    output dec_t       dec
);
    // Classify the instruction and pull out its fields.
    always_comb begin
        dec         = '0;
        dec.kind    = OPK_ILLEGAL;
        dec.idx     = byte1[IDX_W-1:0];
        dec.dst_sel = byte0[2];
        dec.pop     = byte0[1];
        dec.rev     = byte1[3] ^ byte0[2];
        dec.func    = byte1[5:4];
        if (byte0[7:3] == FAMILY_TAG) begin
            if (byte0[2:0] == 3'b001) begin
                if (byte1 == 8'hF7)
                    dec.kind = OPK_TOP_INC;
                else if (byte1 == 8'hF6)
                    dec.kind = OPK_TOP_DEC;
                else if (byte1[7:3] == 5'b11001)
                    dec.kind = OPK_EXCH;
                else if (byte1[7:3] == 5'b11000)
                    dec.kind = OPK_COPY;
                else if (byte1[7:3] == 5'b11101 && byte1[2:0] != 3'b111)
                    dec.kind = OPK_PUSH_RES;
            end else if (byte0[2:0] == 3'b101) begin
                if (byte1[7:3] == 5'b11000)
                    dec.kind = OPK_FREE;
            end else if (byte0[2:0] == 3'b110 && byte1 == 8'hD9) begin
                dec.kind = OPK_POP_TWICE;
            end else if (!byte0[0] && byte0[2:1] != 2'b01 && byte1[7:6] == 2'b11) begin
                dec.kind = OPK_ARITH;
            end
        end
    end
endmodule

// File: rtl/fpstk_map.sv
`timescale 1ns/100ps
// Relative-to-physical index mapper. Assumes the stack depth is a power
// of two, so the modulo reduces to a truncating add.
module fpstk_map #(
    parameter int IW = 3
) (
    input  logic [IW-1:0] top,
    input  logic [IW-1:0] rel,
    output logic [IW-1:0] phys
);
    // Wrap-around add of the relative offset to the top pointer.
    assign phys = top + rel;
endmodule

// File: rtl/fpstk_file.sv
`timescale 1ns/100ps
// Stack storage: eight value slots with per-slot empty tags, two write
// ports (so a swap completes in one edge) and NRD asynchronous read ports.
// Assumes callers never request a tag mark_full and mark_empty for the
// same slot in one cycle.
module fpstk_file
    import fpstk_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NRD    = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wa_en,
    input  logic [IDX_W-1:0]                  wa_addr,
    input  logic [DATA_W-1:0]                 wa_data,
    input  logic                              wb_en,
    input  logic [IDX_W-1:0]                  wb_addr,
    input  logic [DATA_W-1:0]                 wb_data,
    input  logic [STACK_DEPTH-1:0]            mark_empty,
    input  logic [STACK_DEPTH-1:0]            mark_full,
    input  logic [NRD-1:0][IDX_W-1:0]         rd_addr,
    output logic [NRD-1:0][DATA_W-1:0]        rd_data,
    output logic [STACK_DEPTH-1:0]            empty
);
    logic [DATA_W-1:0]      slot_q [STACK_DEPTH];
    logic [STACK_DEPTH-1:0] empty_q;

    // Slot values and tags, cleared to empty on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STACK_DEPTH; k++)
                slot_q[k] <= '0;
            empty_q <= '1;
        end else begin
            if (wa_en)
                slot_q[wa_addr] <= wa_data;
            if (wb_en)
                slot_q[wb_addr] <= wb_data;
            empty_q <= (empty_q & ~mark_full) | mark_empty;
        end
    end

    // One asynchronous read port per requested address.
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = slot_q[rd_addr[r]];
    end

    assign empty = empty_q;
endmodule

// File: rtl/fpstk_ctrl.sv
`timescale 1ns/100ps
// Register stack controller top. Accepts one instruction per cycle,
// maps relative operands through the top pointer, screens for overflow
// and underflow, and applies every stack effect at the accepting edge.
// Assumes res_data is valid in the same cycle op_fire is high.
module fpstk_ctrl
    import fpstk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte0,
    input  logic [7:0]        in_byte1,
    input  logic [DATA_W-1:0] res_data,
    output logic              op_fire,
    output logic [1:0]        op_func,
    output logic              op_reverse,
    output logic [DATA_W-1:0] op_dst_data,
    output logic [DATA_W-1:0] op_src_data,
    input  logic [2:0]        rd_rel,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic [2:0]        top_ptr,
    output logic              bad_op,
    output logic              overflow,
    output logic              underflow
);
    localparam int NMAP = 4;   // ST(i), observation, ST(1), push slot
    localparam int NRD  = 3;   // ST(i), observation, ST(0)

    dec_t dec;
    logic accept, go, unf_hit, ovf_hit;
    logic ready_q, bad_q, ovf_q, unf_q;
    logic [IDX_W-1:0] top_q, top_d;
    logic [NMAP-1:0][IDX_W-1:0] map_rel, map_phys;
    logic [IDX_W-1:0] phys_i, phys_rd, phys_one, phys_push;
    logic [NRD-1:0][IDX_W-1:0]  rd_addr;
    logic [NRD-1:0][DATA_W-1:0] rd_vals;
    logic [DATA_W-1:0] data_i, data_top;
    logic [STACK_DEPTH-1:0] empty, mark_empty, mark_full;
    logic emp_top, emp_i, emp_one, emp_push;
    logic wa_en, wb_en;
    logic [IDX_W-1:0] wa_addr, wb_addr;
    logic [DATA_W-1:0] wa_data, wb_data;

    fpstk_decode u_dec (
        .byte0 (in_byte0),
        .byte1 (in_byte1),
        .dec   (dec)
    );

    assign map_rel[0] = dec.idx;
    assign map_rel[1] = rd_rel;
    assign map_rel[2] = IDX_W'(1);
    assign map_rel[3] = '1;

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        fpstk_map #(.IW(IDX_W)) u_map (
            .top  (top_q),
            .rel  (map_rel[m]),
            .phys (map_phys[m])
        );
    end

    assign phys_i    = map_phys[0];
    assign phys_rd   = map_phys[1];
    assign phys_one  = map_phys[2];
    assign phys_push = map_phys[3];

    assign rd_addr[0] = phys_i;
    assign rd_addr[1] = phys_rd;
    assign rd_addr[2] = top_q;

    fpstk_file #(.DATA_W(DATA_W), .NRD(NRD)) u_file (
        .clk        (clk),
        .rst_n      (rst_n),
        .wa_en      (wa_en),
        .wa_addr    (wa_addr),
        .wa_data    (wa_data),
        .wb_en      (wb_en),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .mark_empty (mark_empty),
        .mark_full  (mark_full),
        .rd_addr    (rd_addr),
        .rd_data    (rd_vals),
        .empty      (empty)
    );

    assign data_i   = rd_vals[0];
    assign data_top = rd_vals[2];
    assign emp_top  = empty[top_q];
    assign emp_i    = empty[phys_i];
    assign emp_one  = empty[phys_one];
    assign emp_push = empty[phys_push];
    assign accept   = in_valid && ready_q;

    // Fault screening: which operand reads or push targets are illegal.
    always_comb begin
        unf_hit = 1'b0;
        ovf_hit = 1'b0;
        case (dec.kind)
            OPK_EXCH, OPK_ARITH: unf_hit = emp_top | emp_i;
            OPK_COPY: begin
                unf_hit = emp_i;
                ovf_hit = !emp_push;
            end
            OPK_PUSH_RES:  ovf_hit = !emp_push;
            OPK_POP_TWICE: unf_hit = emp_top | emp_one;
            default: ;
        endcase
    end

    assign go = accept && !unf_hit && !ovf_hit;

    // Stack effects of the accepted instruction: writes, tags, new top.
    always_comb begin
        top_d      = top_q;
        wa_en      = 1'b0;
        wa_addr    = top_q;
        wa_data    = res_data;
        wb_en      = 1'b0;
        wb_addr    = phys_i;
        wb_data    = data_top;
        mark_empty = '0;
        mark_full  = '0;
        if (go) begin
            case (dec.kind)
                OPK_TOP_INC: top_d = phys_one;
                OPK_TOP_DEC: top_d = phys_push;
                OPK_EXCH: begin
                    wa_en   = 1'b1;
                    wa_data = data_i;
                    wb_en   = 1'b1;
                end
                OPK_COPY: begin
                    wa_en   = 1'b1;
                    wa_addr = phys_push;
                    wa_data = data_i;
                    mark_full[phys_push] = 1'b1;
                    top_d   = phys_push;
                end
                OPK_PUSH_RES: begin
                    wa_en   = 1'b1;
                    wa_addr = phys_push;
                    mark_full[phys_push] = 1'b1;
                    top_d   = phys_push;
                end
                OPK_FREE: mark_empty[phys_i] = 1'b1;
                OPK_POP_TWICE: begin
                    mark_empty[top_q]    = 1'b1;
                    mark_empty[phys_one] = 1'b1;
                    top_d = phys_one + IDX_W'(1);
                end
                OPK_ARITH: begin
                    wa_en   = 1'b1;
                    wa_addr = dec.dst_sel ? phys_i : top_q;
                    if (dec.pop) begin
                        mark_empty[top_q] = 1'b1;
                        top_d = phys_one;
                    end
                end
                default: ;
            endcase
        end
    end

    // Top pointer, handshake readiness, sticky flags and reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q   <= '0;
            ready_q <= 1'b0;
            bad_q   <= 1'b0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            top_q   <= top_d;
            ready_q <= 1'b1;
            bad_q   <= accept && (dec.kind == OPK_ILLEGAL);
            ovf_q   <= ovf_q | (accept && ovf_hit);
            unf_q   <= unf_q | (accept && unf_hit);
        end
    end

    assign in_ready    = ready_q;
    assign op_fire     = go && (dec.kind == OPK_ARITH);
    assign op_func     = dec.func;
    assign op_reverse  = dec.rev;
    assign op_dst_data = dec.dst_sel ? data_i : data_top;
    assign op_src_data = dec.dst_sel ? data_top : data_i;
    assign rd_data     = rd_vals[1];
    assign rd_empty    = empty[phys_rd];
    assign top_ptr     = top_q;
    assign bad_op      = bad_q;
    assign overflow    = ovf_q;
    assign underflow   = unf_q;
endmodule

// File: rtl/fpstk_ctrl_chk.sv
`timescale 1ns/100ps
// Property checker for the register stack controller, bound to every
// instance of the top. Observes ports only.
module fpstk_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic [7:0] in_byte0,
    input logic [7:0] in_byte1,
    input logic       op_fire,
    input logic       op_reverse,
    input logic [2:0] top_ptr,
    input logic       bad_op,
    input logic       overflow,
    input logic       underflow
);
    logic take;
    assign take = in_valid && in_ready;

    assert_reject_accepted_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> $past(take));

    assert_reject_top_still_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> $stable(top_ptr));

    assert_fire_on_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_fire |-> take);

    assert_order_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_fire |-> (op_reverse == (in_byte1[3] ^ in_byte0[2])));

    assert_pop_twice_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_byte0 == 8'hDE && in_byte1 == 8'hD9)
        |=> ((top_ptr == 3'($past(top_ptr) + 3'd2)) || underflow));

    assert_top_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_byte0 == 8'hD9 && in_byte1 == 8'hF7)
        |=> (top_ptr == 3'($past(top_ptr) + 3'd1)));

    assert_top_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_byte0 == 8'hD9 && in_byte1 == 8'hF6)
        |=> (top_ptr == 3'($past(top_ptr) - 3'd1)));

    assert_underflow_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);

    assert_overflow_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

bind fpstk_ctrl fpstk_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_byte0   (in_byte0),
    .in_byte1   (in_byte1),
    .op_fire    (op_fire),
    .op_reverse (op_reverse),
    .top_ptr    (top_ptr),
    .bad_op     (bad_op),
    .overflow   (overflow),
    .underflow  (underflow)
);

// File: tb/fpstk_ctrl_tb_top.sv
`timescale 1ns/100ps
// Self-checking bench: a behavioural stack model is built from the
// requirements and compared against every relative entry after each step.
module fpstk_ctrl_tb_top;
    localparam int  DW  = 16;
    localparam time TCK = 20ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_byte0 = '0;
    logic [7:0]    in_byte1 = '0;
    logic [DW-1:0] res_data = '0;
    logic          op_fire;
    logic [1:0]    op_func;
    logic          op_reverse;
    logic [DW-1:0] op_dst_data, op_src_data;
    logic [2:0]    rd_rel = '0;
    logic [DW-1:0] rd_data;
    logic          rd_empty;
    logic [2:0]    top_ptr;
    logic          bad_op, overflow, underflow;

    always #(TCK/2) clk = ~clk;

    fpstk_ctrl #(.DATA_W(DW)) dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .in_byte0 (in_byte0), .in_byte1 (in_byte1), .res_data (res_data),
        .op_fire (op_fire), .op_func (op_func), .op_reverse (op_reverse),
        .op_dst_data (op_dst_data), .op_src_data (op_src_data),
        .rd_rel (rd_rel), .rd_data (rd_data), .rd_empty (rd_empty),
        .top_ptr (top_ptr), .bad_op (bad_op), .overflow (overflow),
        .underflow (underflow)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [DW-1:0] mreg [8];
    logic [7:0]    memp;
    int            mtop;
    bit            movf, munf, mbad;

    task automatic chk(input string req, input string what, input longint act, input longint expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Instruction class from the requirement encodings.
    function automatic int kind_of(input logic [7:0] b0, input logic [7:0] b1);
        if (b0[7:3] != 5'b11011) return 0;
        if (b0[2:0] == 3'b001) begin
            if (b1 == 8'hF7) return 1;
            if (b1 == 8'hF6) return 2;
            if (b1[7:3] == 5'b11001) return 3;
            if (b1[7:3] == 5'b11000) return 4;
            if (b1[7:3] == 5'b11101 && b1[2:0] != 3'b111) return 5;
            return 0;
        end
        if (b0[2:0] == 3'b101) return (b1[7:3] == 5'b11000) ? 6 : 0;
        if (b0[2:0] == 3'b110 && b1 == 8'hD9) return 7;
        if (!b0[0] && b0[2:1] != 2'b01 && b1[7:6] == 2'b11) return 8;
        return 0;
    endfunction

    task automatic model_step(input logic [7:0] b0, input logic [7:0] b1, input logic [DW-1:0] res);
        int k, a, b, nx, up;
        logic [DW-1:0] t;
        k  = kind_of(b0, b1);
        a  = mtop;
        b  = (mtop + int'(b1[2:0])) % 8;
        nx = (mtop + 1) % 8;
        up = (mtop + 7) % 8;
        mbad = (k == 0);
        case (k)
            1: mtop = nx;
            2: mtop = up;
            3: if (memp[a] || memp[b]) munf = 1'b1;
               else begin t = mreg[a]; mreg[a] = mreg[b]; mreg[b] = t; end
            4: begin
                if (memp[b]) munf = 1'b1;
                if (!memp[up]) movf = 1'b1;
                if (!memp[b] && memp[up]) begin
                    mreg[up] = mreg[b]; memp[up] = 1'b0; mtop = up;
                end
            end
            5: if (!memp[up]) movf = 1'b1;
               else begin mreg[up] = res; memp[up] = 1'b0; mtop = up; end
            6: memp[b] = 1'b1;
            7: if (memp[a] || memp[nx]) munf = 1'b1;
               else begin memp[a] = 1'b1; memp[nx] = 1'b1; mtop = (mtop + 2) % 8; end
            8: if (memp[a] || memp[b]) munf = 1'b1;
               else begin
                   if (b0[2]) mreg[b] = res; else mreg[a] = res;
                   if (b0[1]) begin memp[a] = 1'b1; mtop = nx; end
               end
            default: ;
        endcase
    endtask

    task automatic model_reset();
        for (int k = 0; k < 8; k++) mreg[k] = '0;
        memp = '1; mtop = 0; movf = 0; munf = 0; mbad = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        model_reset();
    endtask

    // Compare pointer, flags and every relative entry with the model.
    task automatic check_state(input string req);
        chk(req, "top_ptr", top_ptr, mtop);
        chk(req, "overflow", overflow, movf);
        chk(req, "underflow", underflow, munf);
        for (int r = 0; r < 8; r++) begin
            rd_rel = 3'(r);
            #0.5;
            chk(req, "rd_empty", rd_empty, memp[(mtop + r) % 8]);
            if (!memp[(mtop + r) % 8])
                chk(req, "rd_data", rd_data, mreg[(mtop + r) % 8]);
        end
    endtask

    // Issue one instruction, check the operand outputs, advance the model.
    task automatic send(input logic [7:0] b0, input logic [7:0] b1, input logic [DW-1:0] res, input string req);
        int k, a, b;
        bit efire;
        k = kind_of(b0, b1);
        a = mtop;
        b = (mtop + int'(b1[2:0])) % 8;
        efire = (k == 8) && !memp[a] && !memp[b];
        @(negedge clk);
        in_valid = 1'b1; in_byte0 = b0; in_byte1 = b1; res_data = res;
        #2;
        chk(req, "op_fire", op_fire, efire);
        if (efire) begin
            chk(req, "op_dst_data", op_dst_data, b0[2] ? mreg[b] : mreg[a]);
            chk(req, "op_src_data", op_src_data, b0[2] ? mreg[a] : mreg[b]);
            chk("R6", "op_reverse", op_reverse, b1[3] ^ b0[2]);
            chk(req, "op_func", op_func, b1[5:4]);
        end
        @(posedge clk);
        model_step(b0, b1, res);
        @(negedge clk);
        in_valid = 1'b0;
        #0.5;
        chk("R1", "bad_op", bad_op, mbad);
    endtask

    initial begin
        #(TCK * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R14: reset state
        chk("R14", "in_ready", in_ready, 1);
        check_state("R14");

        // R12: swap and arithmetic on an empty stack
        send(8'hD9, 8'hC9, 16'h0, "R12");
        check_state("R12");
        send(8'hD8, 8'hC1, 16'h1234, "R12");
        check_state("R12");

        // R3: fill the stack with result pushes, then R13 on the ninth
        do_reset();
        for (int n = 0; n < 8; n++) begin
            send(8'hD9, {5'b11101, 3'(n % 7)}, 16'h1000 + 16'(n * 17), "R3");
            check_state("R3");
        end
        send(8'hD9, 8'hE8, 16'hDEAD, "R13");
        check_state("R13");

        // R1: rejected encodings change nothing
        send(8'hC8, 8'hC0, 16'hBEEF, "R1");
        check_state("R1");
        send(8'hD9, 8'h00, 16'hBEEF, "R1");
        check_state("R1");
        send(8'hDD, 8'hF0, 16'hBEEF, "R1");
        check_state("R1");
        send(8'hDA, 8'hE9, 16'hBEEF, "R1");
        check_state("R1");

        // R5/R6: arithmetic sweep over d, R and every index, no pop
        do_reset();
        for (int n = 0; n < 8; n++) send(8'hD9, 8'hEE, 16'h2000 + 16'(n), "R3");
        for (int d = 0; d < 2; d++)
            for (int r = 0; r < 2; r++)
                for (int i = 0; i < 8; i++) begin
                    send(d ? 8'hDC : 8'hD8, {2'b11, 2'(i), 1'(r), 3'(i)},
                         16'h5000 + 16'(d * 64 + r * 16 + i), "R5");
                    check_state("R5");
                end

        // R2: observation port across a rotated top
        send(8'hD9, 8'hF7, 16'h0, "R9");
        check_state("R2");

        // R10: swap with every index
        for (int i = 0; i < 8; i++) begin
            send(8'hD9, {5'b11001, 3'(i)}, 16'h0, "R10");
            check_state("R10");
        end

        // R9: pointer steps in both directions
        for (int n = 0; n < 10; n++) begin
            send(8'hD9, 8'hF7, 16'h0, "R9");
            check_state("R9");
        end
        for (int n = 0; n < 10; n++) begin
            send(8'hD9, 8'hF6, 16'h0, "R9");
            check_state("R9");
        end

        // R11: free, then R12 on the freed slot
        send(8'hDD, 8'hC3, 16'h0, "R11");
        check_state("R11");
        send(8'hD9, 8'hCB, 16'h0, "R12");
        check_state("R12");

        // R13: copy into a full stack
        send(8'hD9, 8'hC1, 16'h0, "R13");
        check_state("R13");

        // R7, R8, R4: popping arithmetic, pop twice, copy
        do_reset();
        for (int n = 0; n < 4; n++) send(8'hD9, 8'hE9, 16'h3000 + 16'(n), "R3");
        send(8'hDE, 8'hE2, 16'h7777, "R7");
        check_state("R7");
        send(8'hDE, 8'hD9, 16'h0, "R8");
        check_state("R8");
        send(8'hD9, 8'hC0, 16'h0, "R4");
        check_state("R4");
        send(8'hD9, 8'hC1, 16'h0, "R4");
        check_state("R4");
        send(8'hD9, 8'hC5, 16'h0, "R12");
        check_state("R12");

        // R8: pop twice until the stack runs dry, then R12
        for (int n = 0; n < 3; n++) begin
            send(8'hDE, 8'hD9, 16'h0, "R8");
            check_state("R8");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule